// File: doc/BRIEF.md
# Root Port Reset and Link Power Sequencer

This block owns the four reset lines of a PCI Express root port (the MAC core, the PHY, the bridge and the slot's PERST#) and walks them through the two sequences that need fixed timing. A start request drives all four lines into reset together and holds them for a settle period. It then lets all four go together and waits, with a timeout, for the link-up flag from the link training logic. A suspend request raises a turn-off-link request toward the link layer and waits, again with a timeout, for the link training state to report L2 idle. PERST# is driven back into reset only after that state has been reached.

Each sequence ends with a one-cycle completion pulse or with a sticky error. On a link-up timeout the 5-bit training state seen at that moment is captured for diagnosis. All time limits are given in microseconds and turned into clock cycles through a cycles-per-microsecond parameter. A bench can therefore shrink them to a few cycles.

Top module: `port_rst_seq`

## Requirements
- R1: After reset, status_o is 0 (idle), rst_o is 4'hF (all four lines in reset), and done_o, err_o, turnoff_o and err_ltssm_o are all 0.
- R2: A start request that is accepted moves status_o to 1 (hold) on the next edge. rst_o reads 4'hF for exactly HOLD_US*CYC_PER_US cycles. Status then becomes 2 (wait link), and all four lines are released together (rst_o = 4'h0).
- R3: In wait link, the state moves to 3 (link up) once link_up_i is sampled high, provided that happens on or before the LINK_TMO_US*CYC_PER_US-th cycle of the wait. Link-up wins over the timeout on that last cycle. done_o pulses in the cycle the state enters link up.
- R4: If link_up_i stays low for all LINK_TMO_US*CYC_PER_US cycles of wait link, the state becomes 6 (error) and err_o rises. err_ltssm_o holds the value of ltssm_i sampled on the edge that entered error. rst_o stays 4'h0.
- R5: A suspend request in link up moves the state to 4 (wait L2) and raises turnoff_o. When ltssm_i is sampled equal to 5'h14, the state becomes 5 (suspended) and turnoff_o drops. rst_o becomes 4'h8, so only PERST# is in reset. done_o pulses in the cycle the state enters suspended.
- R6: If ltssm_i does not reach 5'h14 within L2_TMO_US*CYC_PER_US cycles of wait L2, the state becomes 6 (error) and err_o rises. turnoff_o drops and PERST# stays released (rst_o = 4'h0).
- R7: A start request is accepted only in idle, suspended or error, and is ignored in every other state. A suspend request is accepted only in link up and is ignored in every other state.
- R8: err_o, once high, stays high until a start request is accepted. On that edge err_o and err_ltssm_o both return to 0.
- R9: done_o is never high for two cycles in a row.
- R10: The rst_o bit positions are: bit 0 MAC, bit 1 PHY, bit 2 bridge, bit 3 PERST#. With RST_ACTIVE_HIGH=1 a bit value of 1 means held in reset. The status_o codes are 0 idle, 1 hold, 2 wait link, 3 link up, 4 wait L2, 5 suspended and 6 error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to run the reset-release and link-up sequence |
| suspend_i | input | 1 | Request to take the link to L2 and reassert PERST# |
| link_up_i | input | 1 | Link-up flag from the link training logic |
| ltssm_i | input | 5 | Current link training state |
| rst_o | output | 4 | Reset lines: MAC, PHY, bridge, PERST# |
| turnoff_o | output | 1 | Turn-off-link request toward the link layer |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky timeout error |
| status_o | output | 3 | Current sequencer state code |
| err_ltssm_o | output | 5 | Training state captured on entry to error |

## Verification
State, reset lines and flags are all registered from the same next-state value. A wrong state therefore shows up at the ports on the very edge where it is taken: status_o gives a wrong code, rst_o gives the wrong pattern, or a done or error flag appears when it should not. A counter that is off by one does not show up as a wrong value. It shows up as a hold, link wait or L2 wait that is one cycle longer or shorter than its limit. The bench therefore checks every cycle of each window, including the boundary cycle on which link-up and the timeout arrive together.

// File: rtl/prs_pkg.sv
package prs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_HOLD  = 3'd1,
      ST_WLINK = 3'd2,
      ST_UP    = 3'd3,
      ST_WL2   = 3'd4,
      ST_SUSP  = 3'd5,
      ST_ERR   = 3'd6
   } prs_state_e;

   localparam int N_RST     = 4;
   localparam int RB_MAC    = 0;
   localparam int RB_PHY    = 1;
   localparam int RB_BRG    = 2;
   localparam int RB_PERST  = 3;
   localparam int LTSSM_W   = 5;

   localparam logic [LTSSM_W-1:0] LTSSM_L2_IDLE = 5'h14;

   localparam logic [N_RST-1:0] RST_ALL_ON  = '1;
   localparam logic [N_RST-1:0] RST_ALL_OFF = '0;
   localparam logic [N_RST-1:0] RST_SLOT_ON = N_RST'(1) << RB_PERST;

endpackage

// File: rtl/prs_timer.sv
module prs_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic [CW-1:0] limit_i,
   output logic          hit_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (cnt_q != '1) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign hit_o = (cnt_q == limit_i);

endmodule

// File: rtl/prs_fsm.sv
module prs_fsm
   import prs_pkg::*;
#(
   parameter int CW       = 8,
   parameter int HOLD_CYC = 4,
   parameter int LINK_CYC = 4,
   parameter int L2_CYC   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               suspend_i,
   input  logic               link_up_i,
   input  logic [LTSSM_W-1:0] ltssm_i,
   input  logic               hit_i,
   output logic               tmr_clr_o,
   output logic [CW-1:0]      limit_o,
   output prs_state_e         st_o,
   output logic [N_RST-1:0]   rst_req_o,
   output logic               turnoff_o,
   output logic               done_o,
   output logic               err_o,
   output logic [LTSSM_W-1:0] err_ltssm_o
);

   localparam logic [CW-1:0] HOLD_LIM = CW'(HOLD_CYC - 1);
   localparam logic [CW-1:0] LINK_LIM = CW'(LINK_CYC - 1);
   localparam logic [CW-1:0] L2_LIM   = CW'(L2_CYC - 1);

   prs_state_e             st_q, st_d;
   logic [N_RST-1:0]       rst_q, rst_d;
   logic                   toff_q, done_q, err_q;
   logic [LTSSM_W-1:0]     el_q;
   logic                   start_ok, susp_ok, at_l2;

   assign start_ok = start_i && (st_q == ST_IDLE || st_q == ST_SUSP || st_q == ST_ERR);
   assign susp_ok  = suspend_i && (st_q == ST_UP);
   assign at_l2    = (ltssm_i == LTSSM_L2_IDLE);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE, ST_SUSP, ST_ERR: if (start_ok) st_d = ST_HOLD;
         ST_HOLD:  if (hit_i) st_d = ST_WLINK;
         ST_WLINK: begin
            if (link_up_i)  st_d = ST_UP;
            else if (hit_i) st_d = ST_ERR;
         end
         ST_UP:    if (susp_ok) st_d = ST_WL2;
         ST_WL2: begin
            if (at_l2)      st_d = ST_SUSP;
            else if (hit_i) st_d = ST_ERR;
         end
         default:  st_d = ST_ERR;
      endcase
   end

   always_comb begin
      unique case (st_q)
         ST_HOLD:  limit_o = HOLD_LIM;
         ST_WLINK: limit_o = LINK_LIM;
         ST_WL2:   limit_o = L2_LIM;
         default:  limit_o = '1;
      endcase
   end

   assign tmr_clr_o = (st_d != st_q);

   always_comb begin
      unique case (st_d)
         ST_IDLE, ST_HOLD: rst_d = RST_ALL_ON;
         ST_SUSP:          rst_d = RST_SLOT_ON;
         default:          rst_d = RST_ALL_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         rst_q  <= RST_ALL_ON;
         toff_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         el_q   <= '0;
      end else begin
         st_q   <= st_d;
         rst_q  <= rst_d;
         toff_q <= (st_d == ST_WL2);
         done_q <= (st_q == ST_WLINK && st_d == ST_UP) ||
                   (st_q == ST_WL2 && st_d == ST_SUSP);
         if (start_ok) begin
            err_q <= 1'b0;
            el_q  <= '0;
         end else if (st_d == ST_ERR && st_q != ST_ERR) begin
            err_q <= 1'b1;
            el_q  <= ltssm_i;
         end
      end
   end

   assign st_o        = st_q;
   assign rst_req_o   = rst_q;
   assign turnoff_o   = toff_q;
   assign done_o      = done_q;
   assign err_o       = err_q;
   assign err_ltssm_o = el_q;

   AST_HOLD_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_HOLD |-> rst_q == RST_ALL_ON);  // R2
   AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WLINK && $past(st_q) == ST_HOLD) |-> rst_q == RST_ALL_OFF);  // R2
   AST_UP_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_UP && $past(st_q) == ST_WLINK) |-> $past(link_up_i));  // R3
   AST_ERR_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_ERR |-> rst_q == RST_ALL_OFF);  // R4
   AST_SLOT_AFTER_L2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SUSP && $past(st_q) == ST_WL2) |-> $past(ltssm_i) == LTSSM_L2_IDLE);  // R5
   AST_TURNOFF_ONLY_WL2: assert property (@(posedge clk) disable iff (!rst_n)
      toff_q |-> st_q == ST_WL2);  // R5
   AST_ERR_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> !rst_q[RB_PERST]);  // R6
   AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HOLD && $past(st_q) != ST_HOLD) |->
      ($past(st_q) == ST_IDLE || $past(st_q) == ST_SUSP || $past(st_q) == ST_ERR));  // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(err_q) && !$past(start_i)) |-> err_q);  // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);  // R9

endmodule

// File: rtl/prs_rst_drv.sv
module prs_rst_drv #(
   parameter int N           = 4,
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] line_o
);

   for (genvar i = 0; i < N; i++) begin : g_line
      if (ACTIVE_HIGH) begin : g_hi
         assign line_o[i] = req_i[i];
      end else begin : g_lo
         assign line_o[i] = ~req_i[i];
      end
   end

endmodule

// File: rtl/port_rst_seq.sv
module port_rst_seq
   import prs_pkg::*;
#(
   parameter int CYC_PER_US      = 100,
   parameter int HOLD_US         = 100000,
   parameter int LINK_TMO_US     = 100000,
   parameter int L2_TMO_US       = 50000,
   parameter bit RST_ACTIVE_HIGH = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       suspend_i,
   input  logic       link_up_i,
   input  logic [4:0] ltssm_i,
   output logic [3:0] rst_o,
   output logic       turnoff_o,
   output logic       done_o,
   output logic       err_o,
   output logic [2:0] status_o,
   output logic [4:0] err_ltssm_o
);

   localparam int HOLD_CYC = HOLD_US * CYC_PER_US;
   localparam int LINK_CYC = LINK_TMO_US * CYC_PER_US;
   localparam int L2_CYC   = L2_TMO_US * CYC_PER_US;
   localparam int MAX_AB   = (HOLD_CYC > LINK_CYC) ? HOLD_CYC : LINK_CYC;
   localparam int MAX_CYC  = (MAX_AB > L2_CYC) ? MAX_AB : L2_CYC;
   localparam int CW       = $clog2(MAX_CYC + 2);

   if (CYC_PER_US < 1) begin : g_bad_rate
      $error("CYC_PER_US must be at least 1");
   end
   if (HOLD_US < 1 || LINK_TMO_US < 1 || L2_TMO_US < 1) begin : g_bad_limit
      $error("every time limit must be at least 1 us");
   end

   logic               tmr_clr, tmr_hit;
   logic [CW-1:0]      tmr_lim;
   prs_state_e         st;
   logic [N_RST-1:0]   rst_req;

   prs_timer #(.CW(CW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (tmr_clr),
      .limit_i (tmr_lim),
      .hit_o   (tmr_hit)
   );

   prs_fsm #(
      .CW       (CW),
      .HOLD_CYC (HOLD_CYC),
      .LINK_CYC (LINK_CYC),
      .L2_CYC   (L2_CYC)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .suspend_i   (suspend_i),
      .link_up_i   (link_up_i),
      .ltssm_i     (ltssm_i),
      .hit_i       (tmr_hit),
      .tmr_clr_o   (tmr_clr),
      .limit_o     (tmr_lim),
      .st_o        (st),
      .rst_req_o   (rst_req),
      .turnoff_o   (turnoff_o),
      .done_o      (done_o),
      .err_o       (err_o),
      .err_ltssm_o (err_ltssm_o)
   );

   prs_rst_drv #(.N(N_RST), .ACTIVE_HIGH(RST_ACTIVE_HIGH)) u_drv (
      .req_i  (rst_req),
      .line_o (rst_o)
   );

   assign status_o = st;

endmodule

// File: tb/port_rst_seq_bench.sv
module port_rst_seq_bench;

   typedef struct {
      logic [2:0] st;
      logic [3:0] rst;
      logic       done;
      logic       err;
      logic       toff;
      logic [4:0] el;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, suspend_i = 1'b0, link_up_i = 1'b0;
   logic [4:0] ltssm_i = 5'h00;
   logic [3:0] rst_o;
   logic       turnoff_o, done_o, err_o;
   logic [2:0] status_o;
   logic [4:0] err_ltssm_o;

   int checks = 0;
   int bad = 0;
   bit finished = 0;
   exp_t q[$];

   always #10 clk = ~clk;

   port_rst_seq #(
      .CYC_PER_US (2),
      .HOLD_US    (3),
      .LINK_TMO_US(5),
      .L2_TMO_US  (4)
   ) u_port_rst_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .suspend_i(suspend_i),
      .link_up_i(link_up_i), .ltssm_i(ltssm_i), .rst_o(rst_o),
      .turnoff_o(turnoff_o), .done_o(done_o), .err_o(err_o),
      .status_o(status_o), .err_ltssm_o(err_ltssm_o)
   );

   // driver: after each rising edge, queue what the ports must show in this cycle
   task automatic step(input logic [2:0] s, input logic [3:0] r, input logic d,
                       input logic e, input logic t, input logic [4:0] el, input string tag);
      exp_t it;
      @(posedge clk);
      #2;
      it.st = s; it.rst = r; it.done = d; it.err = e; it.toff = t; it.el = el; it.tag = tag;
      q.push_back(it);
   endtask

   // monitor: compare at the falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t it;
         it = q.pop_front();
         checks++;
         if (status_o !== it.st || rst_o !== it.rst || done_o !== it.done ||
             err_o !== it.err || turnoff_o !== it.toff || err_ltssm_o !== it.el) begin
            bad++;
            $display("FAIL %s: got st=%0d rst=%h done=%b err=%b toff=%b el=%h exp st=%0d rst=%h done=%b err=%b toff=%b el=%h",
                     it.tag, status_o, rst_o, done_o, err_o, turnoff_o, err_ltssm_o,
                     it.st, it.rst, it.done, it.err, it.toff, it.el);
         end
      end
   end

   initial begin
      #(20 * 20000);
      if (!finished) begin
         finished = 1;
         bad++;
         checks++;
         $display("FAIL watchdog: got no end, exp end of run");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      step(3'd0, 4'hF, 0, 0, 0, 5'h00, "R1");
      step(3'd0, 4'hF, 0, 0, 0, 5'h00, "R1");
      rst_n = 1'b1;
      step(3'd0, 4'hF, 0, 0, 0, 5'h00, "R1");
      // R7 suspend ignored in idle
      suspend_i = 1'b1;
      step(3'd0, 4'hF, 0, 0, 0, 5'h00, "R7");
      suspend_i = 1'b0;

      // R2 hold for 6 cycles, then release together
      start_i = 1'b1;
      step(3'd1, 4'hF, 0, 0, 0, 5'h00, "R2");
      start_i = 1'b0;
      for (int i = 0; i < 5; i++) step(3'd1, 4'hF, 0, 0, 0, 5'h00, "R2");
      step(3'd2, 4'h0, 0, 0, 0, 5'h00, "R2");
      // R3 link-up on the last allowed cycle wins over the timeout
      for (int i = 0; i < 9; i++) step(3'd2, 4'h0, 0, 0, 0, 5'h00, "R3");
      link_up_i = 1'b1;
      step(3'd3, 4'h0, 1, 0, 0, 5'h00, "R3");
      step(3'd3, 4'h0, 0, 0, 0, 5'h00, "R9");
      // R7 start ignored in link up
      start_i = 1'b1;
      step(3'd3, 4'h0, 0, 0, 0, 5'h00, "R7");
      start_i = 1'b0;

      // R5 suspend reaching L2 idle
      suspend_i = 1'b1;
      step(3'd4, 4'h0, 0, 0, 1, 5'h00, "R5");
      suspend_i = 1'b0;
      step(3'd4, 4'h0, 0, 0, 1, 5'h00, "R5");
      step(3'd4, 4'h0, 0, 0, 1, 5'h00, "R5");
      ltssm_i = 5'h14;
      step(3'd5, 4'h8, 1, 0, 0, 5'h00, "R5 R10");
      ltssm_i = 5'h00;
      step(3'd5, 4'h8, 0, 0, 0, 5'h00, "R9");
      // R7 suspend ignored in suspended
      suspend_i = 1'b1;
      step(3'd5, 4'h8, 0, 0, 0, 5'h00, "R7");
      suspend_i = 1'b0;

      // R4 restart from suspended, link never comes up
      link_up_i = 1'b0;
      start_i = 1'b1;
      step(3'd1, 4'hF, 0, 0, 0, 5'h00, "R2");
      start_i = 1'b0;
      step(3'd1, 4'hF, 0, 0, 0, 5'h00, "R2");
      start_i = 1'b1;
      step(3'd1, 4'hF, 0, 0, 0, 5'h00, "R7");
      start_i = 1'b0;
      for (int i = 0; i < 3; i++) step(3'd1, 4'hF, 0, 0, 0, 5'h00, "R2");
      step(3'd2, 4'h0, 0, 0, 0, 5'h00, "R2");
      ltssm_i = 5'h0B;
      for (int i = 0; i < 9; i++) step(3'd2, 4'h0, 0, 0, 0, 5'h00, "R4");
      step(3'd6, 4'h0, 0, 1, 0, 5'h0B, "R4");
      ltssm_i = 5'h01;
      suspend_i = 1'b1;
      step(3'd6, 4'h0, 0, 1, 0, 5'h0B, "R8");
      suspend_i = 1'b0;
      step(3'd6, 4'h0, 0, 1, 0, 5'h0B, "R8");

      // R8 start from error clears err
      start_i = 1'b1;
      step(3'd1, 4'hF, 0, 0, 0, 5'h00, "R8");
      start_i = 1'b0;
      for (int i = 0; i < 5; i++) step(3'd1, 4'hF, 0, 0, 0, 5'h00, "R2");
      step(3'd2, 4'h0, 0, 0, 0, 5'h00, "R2");
      link_up_i = 1'b1;
      step(3'd3, 4'h0, 1, 0, 0, 5'h00, "R3");
      ltssm_i = 5'h03;

      // R6 suspend timeout leaves PERST# released
      suspend_i = 1'b1;
      step(3'd4, 4'h0, 0, 0, 1, 5'h00, "R6");
      suspend_i = 1'b0;
      for (int i = 0; i < 7; i++) step(3'd4, 4'h0, 0, 0, 1, 5'h00, "R6");
      step(3'd6, 4'h0, 0, 1, 0, 5'h03, "R6");
      step(3'd6, 4'h0, 0, 1, 0, 5'h03, "R6");

      @(negedge clk);
      #1;
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

endmodule